// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

A four-bit counter whose state moves only on the rising clock edge. Each edge either loads a parallel word, steps the count up or down, or holds the count. The compile-time parameter `DECADE` selects the count range. In decade mode the counter walks 0 to 9. In binary mode it walks 0 to 15. Loading takes priority over every other control. A count step needs both active-low count enables to be asserted at once. The `up` input sets the direction of each step.

The active-low terminal-count output is combinational. It decodes the state, the direction and the trickle enable, and it does not look at the parallel enable. To chain counters, connect the terminal count of one stage to the trickle enable of the next. The upper stage then steps once on the same edge that the lower stage wraps, with no ripple delay through the chain.

The decade variant can enter a code from 10 to 15 at power-up or through a load. A fixed next-state table brings it back into 0 to 9 within two active counts, in either direction. Terminal count also asserts on the odd illegal codes while counting up.

Top module: `updown_counter`

## Requirements
- R1: When `load_n` is low, `q` takes the value of `din` on the next rising edge, whatever the values of the count enables and `up`.
- R2: When `load_n` is high and both `cnt_en_p_n` and `cnt_en_t_n` are low, `q` steps by one on the rising edge: up when `up` is 1, down when `up` is 0.
- R3: When `load_n` is high and either count enable is high, `q` keeps its value across the edge.
- R4: `tc_n` is 1 whenever `cnt_en_t_n` is 1.
- R5: When `cnt_en_t_n` is 0, `tc_n` is 0 in these cases: `up`=0 with `q`=0; `up`=1 with `q`=9 in decade mode; `up`=1 with `q`=15 in binary mode. `tc_n` follows these inputs combinationally and ignores `cnt_en_p_n`.
- R6: In decade mode, counting up from 9 gives 0 and counting down from 0 gives 9. In binary mode the count wraps between 15 and 0 in both directions.
- R7: In decade mode with `up`=1 and `cnt_en_t_n`=0, `tc_n` is also 0 at codes 11, 13 and 15. It stays 1 at codes 10, 12 and 14.
- R8: In decade mode, counting up from an illegal code gives 10→11, 11→6, 12→13, 13→4, 14→15, 15→2. Counting down gives 10→9, 11→10, 12→9, 13→12, 14→9, 15→14. From any illegal code the state reaches 0–9 within two counts, and a legal state never counts into an illegal one.
- R9: When two stages are chained, with the lower stage's `tc_n` driving the upper stage's `cnt_en_t_n`, the upper stage steps exactly once per full cycle of the lower stage, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Active-low parallel load |
| cnt_en_p_n | input | 1 | Active-low count enable, not seen by terminal count |
| cnt_en_t_n | input | 1 | Active-low count enable that also gates terminal count |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | 4 | Parallel load word |
| q | output | 4 | Counter state |
| tc_n | output | 1 | Active-low terminal count |

## Verification
A vector table drives the decade counter through a set of patterns: loads made while counting is enabled, single-enable holds, both wrap points, and entry at each kind of illegal code. These patterns separate load priority from count, trickle gating from parallel gating, and odd illegal codes from even ones on terminal count. A binary instance checks the wrap at 15 and the up-only decode at 15. It also checks that in down mode 15 is not flagged. A two-stage decade chain is run in both directions. It checks that the upper digit stays put until the edge where the lower digit wraps, and then steps exactly once.

// File: rtl/updown_counter.sv
module updown_counter #(
  parameter bit DECADE = 1'b1
) (
  input  logic       clk,
  input  logic       load_n,
  input  logic       cnt_en_p_n,
  input  logic       cnt_en_t_n,
  input  logic       up,
  input  logic [3:0] din,
  output logic [3:0] q,
  output logic       tc_n
);

  localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

  logic       step;
  logic       at_end;
  logic [3:0] nxt_up;
  logic [3:0] nxt_dn;

  assign step = load_n && !cnt_en_p_n && !cnt_en_t_n;

  always_comb begin
    nxt_up = q + 4'd1;
    nxt_dn = q - 4'd1;
    if (DECADE) begin
      case (q)
        4'd9:    nxt_up = 4'd0;
        4'd10:   nxt_up = 4'd11;
        4'd11:   nxt_up = 4'd6;
        4'd12:   nxt_up = 4'd13;
        4'd13:   nxt_up = 4'd4;
        4'd14:   nxt_up = 4'd15;
        4'd15:   nxt_up = 4'd2;
        default: nxt_up = q + 4'd1;
      endcase
      case (q)
        4'd0:    nxt_dn = 4'd9;
        4'd10:   nxt_dn = 4'd9;
        4'd11:   nxt_dn = 4'd10;
        4'd12:   nxt_dn = 4'd9;
        4'd13:   nxt_dn = 4'd12;
        4'd14:   nxt_dn = 4'd9;
        4'd15:   nxt_dn = 4'd14;
        default: nxt_dn = q - 4'd1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!load_n)   q <= din;
    else if (step) q <= up ? nxt_up : nxt_dn;
  end

  generate
    if (DECADE) begin : g_dec_tc
      assign at_end = up ? (q[3] && q[0]) : (q == 4'd0);
    end else begin : g_bin_tc
      assign at_end = up ? (q == TOP) : (q == 4'd0);
    end
  endgenerate

  assign tc_n = !(!cnt_en_t_n && at_end);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!past_ok)
    !load_n |=> q == $past(din)); // R1
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!past_ok)
    (load_n && (cnt_en_p_n || cnt_en_t_n)) |=> $stable(q)); // R3
  AST_TC_IDLE: assert property (@(posedge clk) disable iff (!past_ok)
    cnt_en_t_n |-> tc_n); // R4
  AST_UP_FLAG: assert property (@(posedge clk) disable iff (!past_ok)
    (!cnt_en_t_n && up && q == TOP) |-> !tc_n); // R5
  AST_LEGAL_STAYS: assert property (@(posedge clk) disable iff (!past_ok)
    (step && q <= TOP) |=> q <= TOP); // R8

endmodule

// File: tb/tb_updown_counter.sv
module tb_updown_counter;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic       ld0 = 1'b1, p0 = 1'b1, t0 = 1'b1, up0 = 1'b1;
  logic [3:0] d0 = 4'd0;
  logic       ld1 = 1'b1, p1 = 1'b1, up1 = 1'b1;
  logic [3:0] d1 = 4'd0;
  logic       ldb = 1'b1, pb = 1'b1, tb_t = 1'b1, upb = 1'b1;
  logic [3:0] db = 4'd0;

  logic [3:0] q0, q1, qb;
  logic       tc0, tc1, tcb;

  updown_counter #(.DECADE(1'b1)) dut (
    .clk(clk), .load_n(ld0), .cnt_en_p_n(p0), .cnt_en_t_n(t0), .up(up0),
    .din(d0), .q(q0), .tc_n(tc0));

  updown_counter #(.DECADE(1'b1)) u_hi (
    .clk(clk), .load_n(ld1), .cnt_en_p_n(p1), .cnt_en_t_n(tc0), .up(up1),
    .din(d1), .q(q1), .tc_n(tc1));

  updown_counter #(.DECADE(1'b0)) u_bin (
    .clk(clk), .load_n(ldb), .cnt_en_p_n(pb), .cnt_en_t_n(tb_t), .up(upb),
    .din(db), .q(qb), .tc_n(tcb));

  // {load_n, p_n, t_n, up, din, expected q, expected tc_n}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b1}, // R1 R4
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd1,  1'b1}, // R2
    {1'b0, 1'b0, 1'b0, 1'b1, 4'd8,  4'd8,  1'b1}, // R1
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd9,  1'b0}, // R2 R5
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd0,  4'd9,  1'b1}, // R3 R4
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd9,  1'b0}, // R3 R5
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd0,  1'b1}, // R6
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd9,  1'b1}, // R6
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0}, // R5
    {1'b0, 1'b0, 1'b0, 1'b1, 4'd10, 4'd10, 1'b1}, // R1 R7
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd11, 1'b0}, // R7 R8
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd6,  1'b1}, // R8
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd13, 4'd13, 1'b1}, // R1
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd12, 1'b1}, // R8
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'd9,  1'b1}, // R8
    {1'b0, 1'b1, 1'b0, 1'b1, 4'd15, 4'd15, 1'b0}, // R7
    {1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  4'd2,  1'b1}  // R8
  };

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    for (int i = 0; i < NV; i++) begin
      {ld0, p0, t0, up0, d0} = VEC[i][12:5];
      tick();
      chk($sformatf("R1-vector%0d q", i), {1'b0, q0}, {1'b0, VEC[i][4:1]});
      chk($sformatf("R4-vector%0d tc", i), {4'd0, tc0}, {4'd0, VEC[i][0]});
    end

    // binary variant: wrap at 15 (R6), decode at 15 only when up (R5)
    {ldb, pb, tb_t, upb, db} = {1'b0, 1'b0, 1'b0, 1'b1, 4'd14};
    tick();
    ldb = 1'b1;
    tick();
    chk("R2 bin up to 15", {1'b0, qb}, 5'd15);
    chk("R5 bin tc at 15 up", {4'd0, tcb}, 5'd0);
    tick();
    chk("R6 bin wrap up", {1'b0, qb}, 5'd0);
    upb = 1'b0;
    #0.5;
    chk("R5 bin tc at 0 down", {4'd0, tcb}, 5'd0);
    tick();
    chk("R6 bin wrap down", {1'b0, qb}, 5'd15);
    chk("R5 bin 15 down not flagged", {4'd0, tcb}, 5'd1);

    // cascade up (R9)
    {ld0, p0, t0, up0, d0} = {1'b0, 1'b0, 1'b0, 1'b1, 4'd0};
    {ld1, p1, up1, d1} = {1'b0, 1'b0, 1'b1, 4'd0};
    tick();
    ld0 = 1'b1;
    ld1 = 1'b1;
    for (int k = 0; k < 9; k++) tick();
    chk("R9 up hi held", {1'b0, q1}, 5'd0);
    chk("R9 up lo at 9", {1'b0, q0}, 5'd9);
    tick();
    chk("R9 up hi stepped", {1'b0, q1}, 5'd1);
    chk("R9 up lo wrapped", {1'b0, q0}, 5'd0);
    for (int k = 0; k < 10; k++) tick();
    chk("R9 up second cycle", {1'b0, q1}, 5'd2);

    // cascade down (R9)
    {ld0, up0, d0} = {1'b0, 1'b0, 4'd0};
    {ld1, up1, d1} = {1'b0, 1'b0, 4'd5};
    tick();
    ld0 = 1'b1;
    ld1 = 1'b1;
    tick();
    chk("R9 down hi stepped", {1'b0, q1}, 5'd4);
    chk("R9 down lo wrapped", {1'b0, q0}, 5'd9);
    for (int k = 0; k < 9; k++) tick();
    chk("R9 down hi held", {1'b0, q1}, 5'd4);
    tick();
    chk("R9 down next step", {1'b0, q1}, 5'd3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #40000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule